// File: doc/BRIEF.md
# Configurable Registered Address Buffer with Parity

This block sits between a memory controller and a bank of memory devices. On each rising clock edge it captures a command/address word and drives it from registers. A static mode input picks the fan-out. In single mode every input bit drives one output on bank A. In dual mode only the low data bits are used, and each one drives both bank A and bank B, so the word can reach twice as many loads.

The two active-low chip selects and the ungated control bits are registered on every edge. The data registers load only when at least one chip select is low, so the address lines do not toggle while no rank is selected. Every loaded word is checked for even parity against a parity bit that arrives one cycle after the word. A mismatch pulls an active-low error flag. A second device can add its partial parity through a cascade input, so that one device reports the error for both.

Top module: `addr_fanout_buf`

## Requirements
- R1: With `mode_i`=0, a word loaded at an edge appears on `qa_o` (bit i = `d_i[i]`) after that edge, and `qb_o` is 0.
- R2: With `mode_i`=1, a loaded word drives `d_i[13:0]` onto both `qa_o[13:0]` and `qb_o[13:0]`, and `qa_o[24:14]` is 0.
- R3: When both `cs_n_i` bits are high at an edge, `qa_o` and `qb_o` keep their values across that edge.
- R4: While `rst_ni` is low, `qa_o`, `qb_o`, `ctl_o` and `cs_n_o` are 0 and `err_no` is 1.
- R5: `cs_n_o` and `ctl_o` take the values of `cs_n_i` and `ctl_i` at every edge, whatever the chip selects are.
- R6: Parity is even. A word loaded at edge k is checked at edge k+1. The checked bits are all 25 in mode 0 and bits 13:0 in mode 1. If the XOR of the checked bits, `par_i` sampled at edge k+1, and the cascade term is 1, then `err_no` is low after edge k+1. Words that were not loaded are not checked.
- R7: Once `err_no` falls it stays low for at least 2 cycles. After that it rises at the first edge that checks a word without a mismatch, and stays low until such a word arrives.
- R8: The cascade term is `casc_par_i` when `casc_en_i` is 1 at the checking edge, and 0 otherwise, so `casc_par_i` has no effect while `casc_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: single fan-out, 1: dual fan-out |
| cs_n_i | input | 2 | Rank selects, active low |
| ctl_i | input | 3 | Ungated control bits |
| d_i | input | 25 | Address/command data |
| par_i | input | 1 | Even-parity bit for the previous word |
| casc_en_i | input | 1 | Enables the cascade parity input |
| casc_par_i | input | 1 | Partial parity from a second device |
| cs_n_o | output | 2 | Registered rank selects |
| ctl_o | output | 3 | Registered control bits |
| qa_o | output | 25 | Bank A data outputs |
| qb_o | output | 14 | Bank B data outputs (dual mode) |
| err_no | output | 1 | Parity error flag, active low |

## Verification
A data register that loads when it should not shows on `qa_o` or `qb_o` one edge after the unselected cycle, because the bench changes the data while both selects are high. A stale or mis-masked parity accumulator shows on `err_no` one edge after the parity bit is sampled. A hold counter that runs short or long shows up within three edges of the first mismatch. A control path that is wrongly gated shows on `ctl_o` in the first unselected cycle.

// File: rtl/addr_fanout_pkg.sv
package addr_fanout_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_DUAL   = 1'b1
  } fan_mode_e;
endpackage

// File: rtl/fan_reg.sv
module fan_reg
  import addr_fanout_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  fan_mode_e           mode_i,
  input  logic [WIDE_W-1:0]   d_i,
  output logic [WIDE_W-1:0]   qa_o,
  output logic [NARROW_W-1:0] qb_o,
  output logic                part_o
);
  logic [WIDE_W-1:0]   qa_d;
  logic [NARROW_W-1:0] qb_d;
  logic [WIDE_W-1:0]   chk_mask;

  for (genvar i = 0; i < WIDE_W; i++) begin : g_lane_a
    if (i < NARROW_W) begin : g_low
      assign qa_d[i]     = d_i[i];
      assign chk_mask[i] = 1'b1;
    end else begin : g_high
      assign qa_d[i]     = (mode_i == MODE_DUAL) ? 1'b0 : d_i[i];
      assign chk_mask[i] = (mode_i == MODE_SINGLE);
    end
  end

  for (genvar j = 0; j < NARROW_W; j++) begin : g_lane_b
    assign qb_d[j] = (mode_i == MODE_DUAL) ? d_i[j] : 1'b0;
  end

  // partial parity of the word being captured
  assign part_o = ^(d_i & chk_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qa_o <= '0;
      qb_o <= '0;
    end else if (load_i) begin
      qa_o <= qa_d;
      qb_o <= qb_d;
    end
  end
endmodule

// File: rtl/ctl_reg.sv
module ctl_reg #(
  parameter int CS_W  = 2,
  parameter int CTL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CS_W-1:0]  cs_n_i,
  input  logic [CTL_W-1:0] ctl_i,
  output logic [CS_W-1:0]  cs_n_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             load_o
);
  assign load_o = ~&cs_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_o <= '0;
      ctl_o  <= '0;
    end else begin
      cs_n_o <= cs_n_i;
      ctl_o  <= ctl_i;
    end
  end
endmodule

// File: rtl/par_chk.sv
module par_chk #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic part_i,
  input  logic par_i,
  input  logic casc_en_i,
  input  logic casc_par_i,
  output logic err_no
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  logic              part_q;
  logic              pend_q;
  logic              err_q;
  logic [HOLD_W-1:0] hold_q;
  logic              mism;

  assign mism   = part_q ^ par_i ^ (casc_en_i & casc_par_i);
  assign err_no = ~err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_q <= 1'b0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      pend_q <= load_i;
      if (load_i) part_q <= part_i;
      if (pend_q && mism) begin
        err_q  <= 1'b1;
        hold_q <= HOLD_W'(HOLD_CYC - 1);
      end else begin
        if (pend_q && hold_q == '0) err_q <= 1'b0;
        if (hold_q != '0) hold_q <= hold_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/addr_fanout_buf.sv
module addr_fanout_buf
  import addr_fanout_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  parameter int CS_W     = 2,
  parameter int CTL_W    = 3,
  parameter int HOLD_CYC = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_i,
  input  logic [CS_W-1:0]     cs_n_i,
  input  logic [CTL_W-1:0]    ctl_i,
  input  logic [WIDE_W-1:0]   d_i,
  input  logic                par_i,
  input  logic                casc_en_i,
  input  logic                casc_par_i,
  output logic [CS_W-1:0]     cs_n_o,
  output logic [CTL_W-1:0]    ctl_o,
  output logic [WIDE_W-1:0]   qa_o,
  output logic [NARROW_W-1:0] qb_o,
  output logic                err_no
);
  logic      load;
  logic      part;
  fan_mode_e mode;

  assign mode = fan_mode_e'(mode_i);

  ctl_reg #(.CS_W(CS_W), .CTL_W(CTL_W)) u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_n_i (cs_n_i),
    .ctl_i  (ctl_i),
    .cs_n_o (cs_n_o),
    .ctl_o  (ctl_o),
    .load_o (load)
  );

  fan_reg #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_fan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .mode_i (mode),
    .d_i    (d_i),
    .qa_o   (qa_o),
    .qb_o   (qb_o),
    .part_o (part)
  );

  par_chk #(.HOLD_CYC(HOLD_CYC)) u_par (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .part_i     (part),
    .par_i      (par_i),
    .casc_en_i  (casc_en_i),
    .casc_par_i (casc_par_i),
    .err_no     (err_no)
  );
endmodule

// File: rtl/addr_fanout_chk.sv
module addr_fanout_chk #(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  parameter int CS_W     = 2,
  parameter int CTL_W    = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                mode_i,
  input logic [CS_W-1:0]     cs_n_i,
  input logic [CTL_W-1:0]    ctl_i,
  input logic [CS_W-1:0]     cs_n_o,
  input logic [CTL_W-1:0]    ctl_o,
  input logic [WIDE_W-1:0]   qa_o,
  input logic [NARROW_W-1:0] qb_o,
  input logic                err_no
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_single_bank_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!mode_i && !(&cs_n_i)) |-> qb_o == '0);

  p_dual_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(mode_i && !(&cs_n_i)) |-> qb_o == qa_o[NARROW_W-1:0]);

  p_hold_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(&cs_n_i) |-> $stable(qa_o) && $stable(qb_o));

  p_reset_state_r4: assert property (@(posedge clk_i)
    !rst_ni |-> err_no && qa_o == '0 && qb_o == '0 && ctl_o == '0);

  p_ctl_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ctl_o == $past(ctl_i) && cs_n_o == $past(cs_n_i));

  p_err_min_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $fell(err_no) |=> !err_no);
endmodule

bind addr_fanout_buf addr_fanout_chk #(
  .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .CS_W(CS_W), .CTL_W(CTL_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .mode_i (mode_i),
  .cs_n_i (cs_n_i),
  .ctl_i  (ctl_i),
  .cs_n_o (cs_n_o),
  .ctl_o  (ctl_o),
  .qa_o   (qa_o),
  .qb_o   (qb_o),
  .err_no (err_no)
);

// File: tb/addr_fanout_buf_test.sv
module addr_fanout_buf_test;
  localparam int WW = 25;
  localparam int NW = 14;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode_i = 1'b0;
  logic [1:0]    cs_n_i = 2'b11;
  logic [2:0]    ctl_i = '0;
  logic [WW-1:0] d_i = '0;
  logic          par_i = 1'b0;
  logic          casc_en_i = 1'b0;
  logic          casc_par_i = 1'b0;
  logic [1:0]    cs_n_o;
  logic [2:0]    ctl_o;
  logic [WW-1:0] qa_o;
  logic [NW-1:0] qb_o;
  logic          err_no;

  addr_fanout_buf uut (.*);

  always #2 clk_i = ~clk_i;

  typedef struct packed {
    logic [WW-1:0] qa;
    logic [NW-1:0] qb;
    logic [2:0]    ctl;
    logic [1:0]    csn;
    logic          err_n;
  } exp_t;

  exp_t  exp_q[$];
  string tagd_q[$];
  string tage_q[$];

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  logic [WW-1:0] m_qa = '0;
  logic [NW-1:0] m_qb = '0;
  logic          m_part = 0, m_wv = 0, m_err = 0;
  int            m_hold = 0;
  logic          prev_par = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic logic wpar(logic md, logic [WW-1:0] d);
    return md ? ^d[NW-1:0] : ^d;
  endfunction

  // drive one cycle at negedge, advance the model, queue expectation
  task automatic drive(logic md, logic [1:0] csn, logic [2:0] ctl, logic [WW-1:0] d,
                       logic flip, logic cen, logic cpar, string tagd, string tage);
    logic ld, par, mism;
    @(negedge clk_i);
    par = prev_par ^ flip;
    mode_i = md; cs_n_i = csn; ctl_i = ctl; d_i = d;
    par_i = par; casc_en_i = cen; casc_par_i = cpar;
    ld   = ~&csn;
    mism = m_part ^ par ^ (cen & cpar);
    if (m_wv && mism) begin
      m_err = 1; m_hold = 1;
    end else begin
      if (m_wv && m_hold == 0) m_err = 0;
      if (m_hold != 0) m_hold--;
    end
    m_wv = ld;
    if (ld) begin
      m_part   = wpar(md, d);
      prev_par = m_part;
      m_qa = md ? {{(WW-NW){1'b0}}, d[NW-1:0]} : d;
      m_qb = md ? d[NW-1:0] : '0;
    end
    exp_q.push_back('{qa: m_qa, qb: m_qb, ctl: ctl, csn: csn, err_n: ~m_err});
    tagd_q.push_back(tagd);
    tage_q.push_back(tage);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        string td, te;
        e = exp_q.pop_front();
        td = tagd_q.pop_front();
        te = tage_q.pop_front();
        chk(td, "qa_o", 32'(qa_o), 32'(e.qa));
        chk(td, "qb_o", 32'(qb_o), 32'(e.qb));
        chk("R5", "ctl_o", 32'(ctl_o), 32'(e.ctl));
        chk("R5", "cs_n_o", 32'(cs_n_o), 32'(e.csn));
        chk(te, "err_no", 32'(err_no), 32'(e.err_n));
      end
    end
  end

  task automatic check_reset();
    #1;
    chk("R4", "qa_o", 32'(qa_o), 0);
    chk("R4", "qb_o", 32'(qb_o), 0);
    chk("R4", "ctl_o", 32'(ctl_o), 0);
    chk("R4", "cs_n_o", 32'(cs_n_o), 0);
    chk("R4", "err_no", 32'(err_no), 1);
  endtask

  task automatic model_reset();
    m_qa = '0; m_qb = '0; m_part = 0; m_wv = 0; m_err = 0; m_hold = 0; prev_par = 0;
  endtask

  initial begin
    #3;
    check_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 single mode, good parity
    drive(0, 2'b10, 3'd1, 25'h1ABCDEF, 0, 0, 0, "R1", "R6");
    drive(0, 2'b01, 3'd2, 25'h0F0F0F0, 0, 0, 0, "R1", "R6");
    drive(0, 2'b00, 3'd3, 25'h1FFFFFF, 0, 0, 0, "R1", "R6");
    // R2 dual mode
    drive(1, 2'b10, 3'd4, 25'h1FF2A55, 0, 0, 0, "R2", "R6");
    drive(1, 2'b01, 3'd5, 25'h0003FFF, 0, 0, 0, "R2", "R6");
    // R3 unselected: data changes, outputs hold, ctl still follows (R5)
    drive(1, 2'b11, 3'd6, 25'h0123456, 0, 0, 0, "R3", "R6");
    drive(0, 2'b11, 3'd7, 25'h1555555, 1, 0, 0, "R3", "R6");
    drive(0, 2'b11, 3'd0, 25'h0AAAAAA, 0, 0, 0, "R3", "R6");
    // R6 bad parity then R7 hold and release
    drive(0, 2'b10, 3'd1, 25'h0000001, 0, 0, 0, "R1", "R6");
    drive(0, 2'b10, 3'd2, 25'h0000003, 1, 0, 0, "R1", "R6");
    drive(0, 2'b10, 3'd3, 25'h0000007, 0, 0, 0, "R1", "R7");
    drive(0, 2'b10, 3'd4, 25'h000000F, 0, 0, 0, "R1", "R7");
    drive(0, 2'b11, 3'd5, 25'h000001F, 0, 0, 0, "R3", "R7");
    // error with no later word stays low
    drive(1, 2'b01, 3'd6, 25'h0000011, 0, 0, 0, "R2", "R7");
    drive(1, 2'b11, 3'd7, 25'h0000000, 1, 0, 0, "R3", "R7");
    drive(1, 2'b11, 3'd0, 25'h0000000, 0, 0, 0, "R3", "R7");
    drive(1, 2'b11, 3'd1, 25'h0000000, 0, 0, 0, "R3", "R7");
    drive(1, 2'b10, 3'd2, 25'h00000F0, 0, 0, 0, "R2", "R7");
    drive(1, 2'b10, 3'd3, 25'h00000F1, 0, 0, 0, "R2", "R7");
    drive(1, 2'b10, 3'd4, 25'h00000F3, 0, 0, 0, "R2", "R7");
    drive(1, 2'b10, 3'd5, 25'h00000F7, 0, 0, 0, "R2", "R7");
    // R8 cascade: compensated, uncompensated, ignored
    drive(0, 2'b10, 3'd6, 25'h1234567, 0, 0, 0, "R1", "R8");
    drive(0, 2'b10, 3'd7, 25'h0765432, 1, 1, 1, "R1", "R8");
    drive(0, 2'b10, 3'd0, 25'h0111111, 0, 1, 1, "R1", "R8");
    drive(0, 2'b10, 3'd1, 25'h0222222, 0, 1, 0, "R1", "R8");
    drive(0, 2'b10, 3'd2, 25'h0333333, 0, 0, 1, "R1", "R8");
    drive(0, 2'b10, 3'd3, 25'h0444444, 0, 0, 1, "R1", "R8");
    drive(0, 2'b10, 3'd4, 25'h0555555, 0, 0, 1, "R1", "R8");
    drive(0, 2'b10, 3'd5, 25'h0666666, 0, 0, 1, "R1", "R8");

    // mixed stimulus
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[0], r[2:1], r[5:3], WW'($urandom), (r[9:6] == 0), r[10], r[11],
            r[0] ? "R2" : "R1", "R6");
    end

    // R4 reset in mid-run
    @(negedge clk_i);
    #0.5;
    rst_ni = 1'b0;
    model_reset();
    check_reset();
    @(posedge clk_i);
    check_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(0, 2'b01, 3'd5, 25'h1357BDF, 0, 0, 0, "R1", "R6");
    drive(0, 2'b01, 3'd6, 25'h02468AC, 0, 0, 0, "R1", "R6");
    @(negedge clk_i);
    @(negedge clk_i);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule